// File: doc/BRIEF.md
# External Interrupt Pin Edge Detector

This block watches one asynchronous external interrupt pin and raises a sticky request flag when the pin makes a qualifying transition. A 4-bit configuration register controls it. One bit picks the active polarity. One bit chooses between detecting only the edge into the active level and detecting every edge. One bit lets the synchronised pin act as a gate for a neighbouring timer. The last bit is a spare that stores its value and does nothing else. The register keeps its value for as long as it is not written, so it survives a low-power back-up period during which the clock runs but no writes occur.

The polarity bit drives three things at once: the edge that counts as a request, the level that the skip-test output reports, and the level that the wake-match output reports to a power-down controller. Edges are found on a polarity-adjusted "active" level. For that reason a write that flips the polarity can set the request flag by itself, and software is expected to clear the flag afterwards. The wake-match output compares the raw pin with the polarity bit combinationally, so it stays meaningful while the clock is stopped.

Top module: `extint_detector`

## Requirements
- R1: After reset the configuration reads 0000, the request flag is 0 and the timer gate is 0. With the pin low, skip and wake-match are both 1. The configuration changes only on a cycle with the write strobe high.
- R2: Bit 3 of the configuration is a spare bit. It reads back as written and changes no output, and writing it sets no request.
- R3: With bit 2 = 0 and bit 1 = 0, a falling pin edge sets the request flag on the third rising clock edge after the pin change. A rising pin edge sets nothing.
- R4: With bit 2 = 1 and bit 1 = 0, a rising pin edge sets the request flag on the third clock edge after the change. A falling pin edge sets nothing.
- R5: With bit 1 = 1, both rising and falling pin edges set the request flag, with the same three-edge latency.
- R6: The request flag stays set until the clear strobe is high at a clock edge. When a detected edge and the clear strobe fall in the same cycle, the flag ends up set.
- R7: A write that changes bit 2 sets the request flag one clock edge after the write in either of two cases: bit 1 = 1, or the synchronised pin is at the newly selected level. A write that leaves bit 2 unchanged sets nothing.
- R8: The skip output is 1 exactly when the synchronised pin equals bit 2 (1 = high level selected). It follows a pin change two clock edges later, and follows a configuration write at once.
- R9: The wake-match output is combinationally 1 when the raw pin equals bit 2, with no clock needed.
- R10: The timer-gate output equals the synchronised pin when bit 0 = 1, and is 0 when bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data (3 spare, 2 polarity, 1 both-edge, 0 timer enable) |
| cfg_rdata_o | output | 4 | Configuration read data |
| req_clr_i | input | 1 | Request flag clear strobe |
| req_flag_o | output | 1 | Sticky interrupt request flag |
| skip_o | output | 1 | Synchronised pin is at the selected level |
| wake_match_o | output | 1 | Raw pin is at the selected return level |
| tmr_gate_o | output | 1 | Timer gate from the synchronised pin |

## Verification
The bench targets the cycle where a polarity write meets a static pin. A design that detects edges on the raw synchronised pin would never set the flag there. A design that ignores the mode bit would set it even when the pin is not at the new level. It drives a pin edge so that its detection lands in the same cycle as a clear. A clear-priority flag would end up empty. It also checks the three-edge latency on both sides, so that a missing synchroniser stage or an extra one shows up as an early or late flag. Wake-match is sampled between clock edges to expose any registering of a path that must work without a clock.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int unsigned CFG_W = 4;

  // Bit positions matter: software writes the register as a nibble.
  localparam int unsigned BIT_TEN   = 0;
  localparam int unsigned BIT_BOTH  = 1;
  localparam int unsigned BIT_POL   = 2;
  localparam int unsigned BIT_SPARE = 3;

  typedef struct packed {
    logic spare;   // bit 3
    logic pol;     // bit 2: 1 = high/rising, 0 = low/falling
    logic both;    // bit 1: 1 = every edge
    logic tmr_en;  // bit 0: pin gates timer
  } cfg_t;

  localparam cfg_t CFG_RESET = '0;

endpackage

// File: rtl/extint_rst_sync.sv
module extint_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/extint_pin_sync.sv
module extint_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = async_i;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/extint_cfg_reg.sv
module extint_cfg_reg
  import extint_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);

  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d = cfg_t'(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
    end else if (we_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q)) else $error("cfg changed without write"); // R1
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q == cfg_t'($past(wdata_i)))) else $error("cfg write lost"); // R2

endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic pol_i,
  input  logic both_i,
  input  logic clr_i,
  output logic act_o,
  output logic req_o
);

  logic act;
  logic act_prev_q;
  logic hit;
  logic req_q;
  logic req_d;

  // Active level normalised to 1 whatever the polarity; a polarity change
  // therefore looks like an edge, which is the intended side effect.
  always_comb begin
    act = (pin_s_i == pol_i);
    if (both_i) begin
      hit = act ^ act_prev_q;
    end else begin
      hit = act & ~act_prev_q;
    end
  end

  always_comb begin
    req_d = req_q;
    if (clr_i) begin
      req_d = 1'b0;
    end
    if (hit) begin
      req_d = 1'b1;
    end
  end

  // The previous sample resets to 1: with pin low and polarity 0 at reset,
  // no request appears when reset is released.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_prev_q <= 1'b1;
      req_q      <= 1'b0;
    end else begin
      act_prev_q <= act;
      req_q      <= req_d;
    end
  end

  assign act_o = act;
  assign req_o = req_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> req_q) else $error("edge did not set flag"); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !clr_i) |=> req_q) else $error("flag dropped without clear"); // R6
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !req_q) else $error("clear ignored"); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && !hit) |=> !req_q) else $error("flag set without edge"); // R3
  AST_SINGLE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_i && hit) |-> act) else $error("single mode hit off level"); // R4

endmodule

// File: rtl/extint_detector.sv
module extint_detector
  import extint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             req_clr_i,
  output logic             req_flag_o,
  output logic             skip_o,
  output logic             wake_match_o,
  output logic             tmr_gate_o
);

  logic rst_n_s;
  logic pin_s;
  logic act;
  cfg_t cfg;

  extint_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  extint_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  extint_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  extint_edge_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .pin_s_i (pin_s),
    .pol_i   (cfg.pol),
    .both_i  (cfg.both),
    .clr_i   (req_clr_i),
    .act_o   (act),
    .req_o   (req_flag_o)
  );

  always_comb begin
    cfg_rdata_o  = cfg;
    skip_o       = act;
    wake_match_o = (pin_i == cfg.pol);
    tmr_gate_o   = cfg.tmr_en & pin_s;
  end

endmodule

// File: tb/extint_detector_test.sv
`timescale 1ns/1ps
module extint_detector_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic       we;
  logic [3:0] wdata;
  logic [3:0] rdata;
  logic       clr;
  logic       flag;
  logic       skip;
  logic       wake;
  logic       gate;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  extint_detector uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pin_i        (pin),
    .cfg_we_i     (we),
    .cfg_wdata_i  (wdata),
    .cfg_rdata_o  (rdata),
    .req_clr_i    (clr),
    .req_flag_o   (flag),
    .skip_o       (skip),
    .wake_match_o (wake),
    .tmr_gate_o   (gate)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] v);
    we = 1'b1; wdata = v;
    tick(1);
    we = 1'b0;
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk("R6 clear", flag, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 cfg reset", rdata, 4'h0);
    chk("R1 flag reset", flag, 1'b0);
    chk("R1 gate reset", gate, 1'b0);
    chk("R1 skip reset", skip, 1'b1);
    chk("R1 wake reset", wake, 1'b1);
    tick(4);
    chk("R1 cfg held", rdata, 4'h0);
  endtask

  task automatic t_fall_single();
    pin = 1'b1;
    tick(3);
    chk("R3 rising ignored", flag, 1'b0);
    chk("R8 skip off level", skip, 1'b0);
    pin = 1'b0;
    tick(2);
    chk("R3 not before third edge", flag, 1'b0);
    chk("R8 skip on level", skip, 1'b1);
    tick(1);
    chk("R3 falling sets", flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_pol_change();
    wr(4'b0100);
    tick(1);
    chk("R7 single, pin off new level", flag, 1'b0);
    wr(4'b0000);
    chk("R7 not yet latched", flag, 1'b0);
    tick(1);
    chk("R7 single, pin at new level", flag, 1'b1);
    clear_flag();
    wr(4'b0010);
    tick(1);
    chk("R7 no polarity change", flag, 1'b0);
    wr(4'b0110);
    tick(1);
    chk("R7 both mode polarity change", flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_rise_single();
    wr(4'b0100);
    tick(1);
    chk("R4 mode write only", flag, 1'b0);
    pin = 1'b1;
    tick(2);
    chk("R8 skip high selected", skip, 1'b1);
    chk("R4 not before third edge", flag, 1'b0);
    tick(1);
    chk("R4 rising sets", flag, 1'b1);
    clear_flag();
    pin = 1'b0;
    tick(3);
    chk("R4 falling ignored", flag, 1'b0);
    chk("R8 skip low pin high sel", skip, 1'b0);
    chk("R9 wake low pin high sel", wake, 1'b0);
  endtask

  task automatic t_both();
    wr(4'b0110);
    pin = 1'b1;
    tick(3);
    chk("R5 rising in both mode", flag, 1'b1);
    clear_flag();
    pin = 1'b0;
    tick(3);
    chk("R5 falling in both mode", flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_set_wins();
    pin = 1'b1;
    tick(2);
    clr = 1'b1;
    tick(1);
    chk("R6 set beats clear", flag, 1'b1);
    tick(1);
    chk("R6 clear after", flag, 1'b0);
    clr = 1'b0;
    pin = 1'b0;
    tick(3);
    chk("R6 set", flag, 1'b1);
    tick(5);
    chk("R6 held without clear", flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_wake();
    pin = 1'b1;
    #0.5;
    chk("R9 wake without clock", wake, 1'b1);
    pin = 1'b0;
    #0.5;
    chk("R9 wake drops", wake, 1'b0);
    tick(3);
    chk("R9 glitch no request", flag, 1'b0);
  endtask

  task automatic t_gate();
    wr(4'b0111);
    chk("R10 gate pin low", gate, 1'b0);
    pin = 1'b1;
    tick(1);
    chk("R10 gate synchroniser delay", gate, 1'b0);
    tick(1);
    chk("R10 gate follows pin", gate, 1'b1);
    tick(1);
    clear_flag();
    wr(4'b0110);
    chk("R10 gate disabled", gate, 1'b0);
    wr(4'b0111);
    chk("R10 gate re-enabled", gate, 1'b1);
  endtask

  task automatic t_spare();
    wr(4'b1111);
    chk("R2 spare readback", rdata, 4'b1111);
    tick(1);
    chk("R2 spare sets no flag", flag, 1'b0);
    chk("R2 spare skip unchanged", skip, 1'b1);
    chk("R2 spare gate unchanged", gate, 1'b1);
    wr(4'b0111);
    chk("R2 spare cleared", rdata, 4'b0111);
    tick(1);
    chk("R2 clearing spare sets no flag", flag, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; we = 1'b0; wdata = 4'h0; clr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_fall_single();
    t_pol_change();
    t_rise_single();
    t_both();
    t_set_wins();
    t_wake();
    t_gate();
    t_spare();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule